// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits between the clock dividers of a multi-output clock generator and its output pins. Each output has its own source clock and its own enable bit. An output opens and closes only on a falling edge of its own source, so it never emits a shortened high pulse. A global tristate control drives the shared output-enable line. The block also picks the frequency-select code from one of two sources: the strap pins, captured once after reset, or a register field.

An asynchronous active-low power-down input is synchronized to the always-on reference clock. A sequencer then closes every output gate. Only after all gates are seen closed does it remove the VCO enable, and one cycle later the crystal-oscillator enable. On release, the sequencer turns the crystal on first and the VCO second. Each step is timed by a parameterized reference-clock counter, and the outputs stay low until both counts have expired.

Top module: `clkout_pd_seq`

## Requirements
- R1: While `rst_ni` is low every `clk_o` bit is 0 and `vco_en_o` and `xtal_en_o` are 1. After reset every enabled output toggles.
- R2: `out_en_i[k]`=0 holds `clk_o[k]` low. When it returns to 1 the output runs again. Every high pulse on `clk_o[k]` lasts exactly as long as the high phase of `src_clk_i[k]`, so an enable change never produces a runt pulse.
- R3: `oe_o` is 0 while `tristate_i` is 1, and 1 otherwise.
- R4: While `pd_ni` is held low, every output ends up low and stays low. No output emits a shortened pulse while it is stopping.
- R5: `vco_en_o` is 0 only while every output gate is closed. `xtal_en_o` is 0 only while `vco_en_o` is 0, and it falls at least one reference cycle after `vco_en_o`.
- R6: After `pd_ni` rises from sleep, `xtal_en_o` rises on the 3rd rising reference edge. `vco_en_o` rises `XTAL_CYC` edges later. No output goes high before a further `LOCK_CYC` edges have passed, and all enabled outputs are running again within a bounded number of edges.
- R7: A power-down request that is released before the gates have all closed returns the block to running. In that case `vco_en_o` and `xtal_en_o` never drop.
- R8: With `fs_mode_i`=0, `fs_sel_o` equals the `fs_pin_i` value captured on the first rising reference edge after reset release. Later changes on `fs_pin_i` have no effect.
- R9: With `fs_mode_i`=1, `fs_sel_o` equals `fs_reg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Always-on reference clock for synchronizer, sequencer and counters |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | N_OUT | Divided source clock per output |
| out_en_i | input | N_OUT | Per-output run enable (1 = run) |
| tristate_i | input | 1 | Global tristate request |
| pd_ni | input | 1 | Asynchronous active-low power-down |
| fs_mode_i | input | 1 | Frequency-select source (0 = captured pins, 1 = register) |
| fs_pin_i | input | FS_W | Strap pin frequency code |
| fs_reg_i | input | FS_W | Register frequency code |
| clk_o | output | N_OUT | Gated output clocks |
| oe_o | output | 1 | Output-driver enable |
| vco_en_o | output | 1 | VCO enable |
| xtal_en_o | output | 1 | Crystal-oscillator enable |
| fs_sel_o | output | FS_W | Selected frequency code |

## Verification
The gate closing for power-down and the power-down release can land in the same window. When they do, the drain phase must turn back without touching either oscillator enable. The bench provokes this with a power-down pulse of four reference cycles. That pulse is shorter than the time the slowest output needs to report its gate closed. The bench then confirms that neither enable ever falls and that no output shows a shortened pulse. A free-running monitor measures the width of every high pulse on every output against its source's half period. This judges gate timing across the enable toggles, the drain, the sleep and the wake-up.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_DRAIN, ST_VCO_OFF, ST_SLEEP, ST_WAKE_XTAL, ST_WAKE_VCO
  } pd_state_e;
endpackage

// File: rtl/ckg_sync2.sv
module ckg_sync2 #(
  parameter int  W       = 1,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/ckg_gate_cell.sv
module ckg_gate_cell (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  output logic clk_o,
  output logic gate_o
);
  logic run_s1_q, run_s2_q, gate_q;

  // all state moves on the source falling edge: the output is low there
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_s1_q <= 1'b0;
      run_s2_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      run_s1_q <= run_i;
      run_s2_q <= run_s1_q;
      gate_q   <= run_s2_q & en_i;
    end
  end

  assign clk_o  = src_clk_i & gate_q;
  assign gate_o = gate_q;

  p_off_holds_low_r2: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_q);
  p_stop_closes_gate_r4: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    !run_s2_q |=> !gate_q);
endmodule

// File: rtl/ckg_pd_seq.sv
module ckg_pd_seq
  import ckg_pkg::*;
#(
  parameter int N_OUT    = 7,
  parameter int XTAL_CYC = 16,
  parameter int LOCK_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [N_OUT-1:0] gate_i,
  output logic             run_o,
  output logic             vco_en_o,
  output logic             xtal_en_o
);
  localparam int MAXC = (XTAL_CYC > LOCK_CYC) ? XTAL_CYC : LOCK_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic             pd_s;
  logic [N_OUT-1:0] gate_s;
  pd_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  ckg_sync2 #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_ni), .q_o(pd_s));
  ckg_sync2 #(.W(N_OUT), .RST_VAL(1'b0)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN:       if (!pd_s) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (pd_s)             st_d = ST_RUN;
        else if (gate_s == '0) st_d = ST_VCO_OFF;
      end
      ST_VCO_OFF:   st_d = ST_SLEEP;
      ST_SLEEP: if (pd_s) begin
        st_d  = ST_WAKE_XTAL;
        cnt_d = '0;
      end
      ST_WAKE_XTAL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(XTAL_CYC - 1)) begin
          st_d  = ST_WAKE_VCO;
          cnt_d = '0;
        end
      end
      ST_WAKE_VCO: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(LOCK_CYC - 1)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
      end
      default:      st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o     = (st_q == ST_RUN);
  assign vco_en_o  = (st_q == ST_RUN) || (st_q == ST_DRAIN) || (st_q == ST_WAKE_VCO);
  assign xtal_en_o = (st_q != ST_SLEEP);

  p_xtal_after_vco_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtal_en_o |-> !vco_en_o);
  p_xtal_lags_vco_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vco_en_o) |-> xtal_en_o);
  p_wake_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE_XTAL) |-> (cnt_q < CW'(XTAL_CYC)));
  p_no_run_in_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE_VCO) |=> (vco_en_o && xtal_en_o));
endmodule

// File: rtl/ckg_fs_select.sv
module ckg_fs_select #(
  parameter int FS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [FS_W-1:0] pin_i,
  input  logic [FS_W-1:0] reg_i,
  output logic [FS_W-1:0] fs_o
);
  logic [FS_W-1:0] strap_q;
  logic            taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      taken_q <= 1'b0;
    end else if (!taken_q) begin
      strap_q <= pin_i;
      taken_q <= 1'b1;
    end
  end

  assign fs_o = mode_i ? reg_i : strap_q;

  p_strap_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |=> $stable(strap_q));
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq #(
  parameter int N_OUT    = 7,
  parameter int FS_W     = 5,
  parameter int XTAL_CYC = 16,
  parameter int LOCK_CYC = 32
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] src_clk_i,
  input  logic [N_OUT-1:0] out_en_i,
  input  logic             tristate_i,
  input  logic             pd_ni,
  input  logic             fs_mode_i,
  input  logic [FS_W-1:0]  fs_pin_i,
  input  logic [FS_W-1:0]  fs_reg_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             oe_o,
  output logic             vco_en_o,
  output logic             xtal_en_o,
  output logic [FS_W-1:0]  fs_sel_o
);
  logic             run;
  logic [N_OUT-1:0] gate_vec;

  ckg_pd_seq #(.N_OUT(N_OUT), .XTAL_CYC(XTAL_CYC), .LOCK_CYC(LOCK_CYC)) u_seq (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .gate_i(gate_vec),
    .run_o(run), .vco_en_o(vco_en_o), .xtal_en_o(xtal_en_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    ckg_gate_cell u_cell (
      .src_clk_i(src_clk_i[k]), .rst_ni(rst_ni), .run_i(run),
      .en_i(out_en_i[k]), .clk_o(clk_o[k]), .gate_o(gate_vec[k]));
  end

  ckg_fs_select #(.FS_W(FS_W)) u_fs (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .mode_i(fs_mode_i),
    .pin_i(fs_pin_i), .reg_i(fs_reg_i), .fs_o(fs_sel_o));

  assign oe_o = ~tristate_i;

  p_vco_off_gates_closed_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !vco_en_o |-> (gate_vec == '0));
  p_quiet_when_off_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !xtal_en_o |-> (clk_o == '0));
endmodule

// File: tb/tb_clkout_pd_seq.sv
module tb_clkout_pd_seq;
  localparam int N     = 7;
  localparam int FW    = 5;
  localparam int XC    = 16;
  localparam int LC    = 32;
  localparam int HMAX  = N;
  localparam int BOUND = 3 + XC + LC + 8 * HMAX + 6;

  logic          ref_clk = 1'b0;
  logic          rst_ni  = 1'b0;
  logic [N-1:0]  src     = '0;
  logic [N-1:0]  en      = '1;
  logic          tri_s   = 1'b0;
  logic          pd_n    = 1'b1;
  logic          mode    = 1'b0;
  logic [FW-1:0] pins    = 5'h13;
  logic [FW-1:0] regv    = 5'h00;
  logic [N-1:0]  clk_o;
  logic          oe, vco, xtal;
  logic [FW-1:0] fs;

  int errors = 0, checks = 0;
  int div_cnt [N];
  int hi_cnt  [N];
  int pulses  [N];

  clkout_pd_seq #(.N_OUT(N), .FS_W(FW), .XTAL_CYC(XC), .LOCK_CYC(LC)) dut (
    .ref_clk_i(ref_clk), .rst_ni(rst_ni), .src_clk_i(src), .out_en_i(en),
    .tristate_i(tri_s), .pd_ni(pd_n), .fs_mode_i(mode), .fs_pin_i(pins),
    .fs_reg_i(regv), .clk_o(clk_o), .oe_o(oe), .vco_en_o(vco),
    .xtal_en_o(xtal), .fs_sel_o(fs));

  always #10 ref_clk = ~ref_clk;

  initial for (int k = 0; k < N; k++) begin
    div_cnt[k] = 0; hi_cnt[k] = 0; pulses[k] = 0;
  end

  // source k: half period of k+1 reference cycles
  always @(posedge ref_clk)
    for (int k = 0; k < N; k++) begin
      if (div_cnt[k] == k) begin
        div_cnt[k] = 0;
        src[k] <= ~src[k];
      end else div_cnt[k] = div_cnt[k] + 1;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse-width monitor: every high pulse must be a full source high phase (R2, R4)
  always @(negedge ref_clk)
    for (int k = 0; k < N; k++) begin
      if (clk_o[k]) hi_cnt[k]++;
      else if (hi_cnt[k] != 0) begin
        chk($sformatf("R2/R4 pulse width out%0d", k), hi_cnt[k], k + 1);
        pulses[k]++;
        hi_cnt[k] = 0;
      end
    end

  task automatic clear_pulses();
    for (int k = 0; k < N; k++) pulses[k] = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // {mode, reg, tristate, exp_fs, exp_oe}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 5'h05, 1'b0, 5'h13, 1'b1},
    {1'b1, 5'h05, 1'b0, 5'h05, 1'b1},
    {1'b1, 5'h1A, 1'b1, 5'h1A, 1'b0},
    {1'b0, 5'h1A, 1'b1, 5'h13, 1'b0},
    {1'b1, 5'h00, 1'b0, 5'h00, 1'b1},
    {1'b1, 5'h1F, 1'b1, 5'h1F, 1'b0}
  };

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 reset clk_o", int'(clk_o), 0);
    chk("R1 reset vco_en", int'(vco), 1);
    chk("R1 reset xtal_en", int'(xtal), 1);
    rst_ni = 1'b1;
    cyc(4);
    pins = 5'h0C;  // must be ignored (R8)
    cyc(2);

    for (int i = 0; i < 6; i++) begin
      mode  = VEC[i][12];
      regv  = VEC[i][11:7];
      tri_s = VEC[i][6];
      cyc(1);
      chk($sformatf("R8/R9 fs_sel vec%0d", i), int'(fs), int'(VEC[i][5:1]));
      chk($sformatf("R3 oe vec%0d", i), int'(oe), int'(VEC[i][0]));
    end
    tri_s = 1'b0; mode = 1'b0;

    cyc(60); clear_pulses(); cyc(40);
    for (int k = 0; k < N; k++)
      chk($sformatf("R1 out%0d toggles", k), int'(pulses[k] > 0), 1);

    // R2 enable off then on
    @(posedge ref_clk); #3 en[2] = 1'b0;
    cyc(20); clear_pulses(); cyc(40);
    chk("R2 disabled out2 quiet", pulses[2], 0);
    chk("R2 other outs run", int'(pulses[5] > 0), 1);
    #3 en[2] = 1'b1;
    cyc(20); clear_pulses(); cyc(40);
    chk("R2 re-enabled out2 runs", int'(pulses[2] > 0), 1);

    // R7 short power-down pulse collides with the drain
    begin
      int vco_drop = 0;
      pd_n = 1'b0; cyc(4); pd_n = 1'b1;
      for (int c = 0; c < 80; c++) begin
        cyc(1);
        if (!vco || !xtal) vco_drop++;
      end
      chk("R7 enables never dropped", vco_drop, 0);
    end
    clear_pulses(); cyc(40);
    chk("R7 outputs running after abort", int'(pulses[6] > 0), 1);

    // R4 and R5: full power-down
    begin
      int bad_vco = 0, bad_xtal = 0;
      logic prev_vco = 1'b1;
      pd_n = 1'b0;
      for (int c = 0; c < 200; c++) begin
        cyc(1);
        if (!vco && clk_o != '0) bad_vco++;
        if (!xtal && prev_vco) bad_xtal++;
        prev_vco = vco;
      end
      chk("R5 vco off only with outputs low", bad_vco, 0);
      chk("R5 xtal off only after vco off", bad_xtal, 0);
      chk("R5 vco off in sleep", int'(vco), 0);
      chk("R5 xtal off in sleep", int'(xtal), 0);
      chk("R4 outputs low", int'(clk_o), 0);
      clear_pulses(); cyc(60);
      for (int k = 0; k < N; k++)
        chk($sformatf("R4 out%0d stays low", k), pulses[k], 0);
    end

    // R6 wake-up timing
    begin
      int n = 0, t_x = -1, t_v = -1, early = 0;
      int first_hi [N];
      for (int k = 0; k < N; k++) first_hi[k] = -1;
      @(negedge ref_clk); pd_n = 1'b1;
      for (int c = 0; c < BOUND; c++) begin
        @(posedge ref_clk); n++;
        @(negedge ref_clk);
        if (xtal && t_x < 0) t_x = n;
        if (vco && t_v < 0) t_v = n;
        for (int k = 0; k < N; k++)
          if (clk_o[k] && first_hi[k] < 0) first_hi[k] = n;
        if (clk_o != '0 && n <= 3 + XC + LC) early++;
      end
      chk("R6 xtal_en rise edge", t_x, 3);
      chk("R6 vco_en rise edge", t_v, 3 + XC);
      chk("R6 no output before lock", early, 0);
      for (int k = 0; k < N; k++)
        chk($sformatf("R6 out%0d back within bound", k), int'(first_hi[k] > 0), 1);
    end
    chk("R8 pins still ignored", int'(fs), 5'h13);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule